// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block collects completion events from a sixteen-channel DMA engine and turns them into a single interrupt line. Each channel reports three kinds of event as one-cycle pulses: half of a transfer moved, one descriptor finished, and a whole descriptor chain finished. Every pulse sets a sticky pending bit. Software reads the pending bits and clears them by writing ones back. Each pending bit has a matching enable bit, and the interrupt output is raised only for pending bits that are enabled.

The channels are split into groups of eight. Each group owns one 32-bit enable register and one 32-bit pending register. Inside a register, each channel takes a four-bit field. A read-only summary register shows which channels have any event pending. Software uses a plain 32-bit register port: a write strobe with address and data, and read data that follows the address in the same cycle. The port has no back-pressure, because every access completes in the cycle it is presented.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset every enable and pending bit is 0, every mapped register reads 0, and `irq` is 0.
- R2: The enable register for channels 0-7 is at 0x00, and the one for channels 8-15 is at 0x04. Channel n uses bits [(n mod 8)*4+3 : (n mod 8)*4]. Bits 0..2 of that field take the written value. Bit 3 always reads 0 and ignores writes.
- R3: A pulse on `ev_half[n]`, `ev_pkg[n]` or `ev_queue[n]` sets field bit 0, 1 or 2 of channel n in the pending register: 0x10 for channels 0-7, 0x14 for channels 8-15. The bit reads back as set from the cycle after the pulse, whatever the enable bits hold. A pending bit never sets without an event.
- R4: A write to a pending register clears each bit written as 1. Bits written as 0 keep their value.
- R5: When an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R6: `irq` is registered. In each cycle it shows whether, in the cycle before, any pending bit had its enable bit set.
- R7: The register at 0x30 is read-only. Its bit n is 1 while channel n has any pending bit set. Bits 31:16 read 0, and writes to this register change no state.
- R8: Any address other than 0x00, 0x04, 0x10, 0x14 and 0x30 reads 0, and writes to it change no state.
- R9: Writing 0 to both enable registers holds `irq` low while the pending bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for both reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ev_half | input | 16 | Per-channel half-transfer event pulses |
| ev_pkg | input | 16 | Per-channel descriptor-done event pulses |
| ev_queue | input | 16 | Per-channel chain-done event pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default values: sixteen channels in groups of eight. Both register pairs and both offsets are therefore exercised. With all-ones event and write patterns, the bench reaches the top nibble of each register (channels 7 and 15) and every reserved bit. With two groups, the bench can also show that the interrupt comes from one group's enables while the other group is masked, and that the summary register collects pending state from both halves.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W  = 32;
  localparam int NIB_W  = 4;
  localparam int EVT_N  = 3;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_EN_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ST_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SUMMARY = 8'h30;
  localparam int                REG_STRIDE  = 4;

  // bit positions of the event kinds inside a channel nibble
  localparam int BIT_HALF  = 0;
  localparam int BIT_PKG   = 1;
  localparam int BIT_QUEUE = 2;

  function automatic logic [REG_W-1:0] rsvd_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W / NIB_W; i++) m[i*NIB_W + NIB_W - 1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dma_irq_group.sv
module dma_irq_group
  import dma_irq_pkg::*;
#(
  parameter int CH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_we,
  input  logic                st_we,
  input  logic [REG_W-1:0]    wdata,
  input  logic [CH-1:0]       ev_half,
  input  logic [CH-1:0]       ev_pkg,
  input  logic [CH-1:0]       ev_queue,
  output logic [REG_W-1:0]    en_q,
  output logic [REG_W-1:0]    st_q,
  output logic [CH-1:0]       ch_pend,
  output logic                hit
);
  localparam int USED_W = CH * NIB_W;

  logic [CH-1:0] unused_rsvd;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [EVT_N-1:0] en_r, st_r, set_v, clr_v;

    assign set_v[BIT_HALF]  = ev_half[c];
    assign set_v[BIT_PKG]   = ev_pkg[c];
    assign set_v[BIT_QUEUE] = ev_queue[c];
    assign clr_v = st_we ? wdata[c*NIB_W +: EVT_N] : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r <= '0;
        st_r <= '0;
      end else begin
        if (en_we) en_r <= wdata[c*NIB_W +: EVT_N];
        st_r <= (st_r & ~clr_v) | set_v;  // a new event outranks a clear
      end
    end

    assign en_q[c*NIB_W +: NIB_W] = {1'b0, en_r};
    assign st_q[c*NIB_W +: NIB_W] = {1'b0, st_r};
    assign ch_pend[c]     = |st_r;
    assign unused_rsvd[c] = wdata[c*NIB_W + NIB_W - 1];
  end

  if (USED_W < REG_W) begin : g_pad
    assign en_q[REG_W-1:USED_W] = '0;
    assign st_q[REG_W-1:USED_W] = '0;
  end

  assign hit = |(st_q & en_q);
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int NUM_CH = 16
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [GROUPS*REG_W-1:0]  en_all,
  input  logic [GROUPS*REG_W-1:0]  st_all,
  input  logic [NUM_CH-1:0]        summary,
  output logic [REG_W-1:0]         rdata
);
  int gi;

  always_comb begin
    rdata = '0;
    gi    = int'(addr[3:2]);
    if (addr[1:0] == 2'b00 && gi < GROUPS) begin
      if (addr[ADDR_W-1:4] == OFS_EN_BASE[ADDR_W-1:4])
        rdata = en_all[gi*REG_W +: REG_W];
      else if (addr[ADDR_W-1:4] == OFS_ST_BASE[ADDR_W-1:4])
        rdata = st_all[gi*REG_W +: REG_W];
    end
    if (addr == OFS_SUMMARY) rdata = REG_W'(summary);
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_PER_REG = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  input  logic [NUM_CH-1:0]   ev_half,
  input  logic [NUM_CH-1:0]   ev_pkg,
  input  logic [NUM_CH-1:0]   ev_queue,
  output logic                irq
);
  localparam int GROUPS = NUM_CH / CH_PER_REG;

  logic [GROUPS*REG_W-1:0] en_all, st_all;
  logic [NUM_CH-1:0]       summary;
  logic [GROUPS-1:0]       hits;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic en_we, st_we;
    assign en_we = wr_en && (addr == ADDR_W'(OFS_EN_BASE + g*REG_STRIDE));
    assign st_we = wr_en && (addr == ADDR_W'(OFS_ST_BASE + g*REG_STRIDE));

    dma_irq_group #(.CH(CH_PER_REG)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_we    (en_we),
      .st_we    (st_we),
      .wdata    (wdata),
      .ev_half  (ev_half [g*CH_PER_REG +: CH_PER_REG]),
      .ev_pkg   (ev_pkg  [g*CH_PER_REG +: CH_PER_REG]),
      .ev_queue (ev_queue[g*CH_PER_REG +: CH_PER_REG]),
      .en_q     (en_all[g*REG_W +: REG_W]),
      .st_q     (st_all[g*REG_W +: REG_W]),
      .ch_pend  (summary[g*CH_PER_REG +: CH_PER_REG]),
      .hit      (hits[g])
    );
  end

  dma_irq_rdmux #(.GROUPS(GROUPS), .NUM_CH(NUM_CH)) u_rd (
    .addr    (addr),
    .en_all  (en_all),
    .st_all  (st_all),
    .summary (summary),
    .rdata   (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |hits;
  end
endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_PER_REG = 8
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   wr_en,
  input logic [ADDR_W-1:0]                      addr,
  input logic [REG_W-1:0]                       wdata,
  input logic [NUM_CH-1:0]                      ev_half,
  input logic [NUM_CH-1:0]                      ev_pkg,
  input logic [NUM_CH-1:0]                      ev_queue,
  input logic                                   irq,
  input logic [(NUM_CH/CH_PER_REG)*REG_W-1:0]   en_all,
  input logic [(NUM_CH/CH_PER_REG)*REG_W-1:0]   st_all
);
  localparam int GROUPS = NUM_CH / CH_PER_REG;
  localparam int ALL_W  = GROUPS * REG_W;
  localparam logic [REG_W-1:0] RSV = rsvd_mask();

  logic [ALL_W-1:0] set_v, clr_v, rsv_all;

  for (genvar g = 0; g < GROUPS; g++) begin : g_g
    logic hit_st;
    assign hit_st = wr_en && (addr == ADDR_W'(OFS_ST_BASE + g*REG_STRIDE));
    assign rsv_all[g*REG_W +: REG_W] = RSV;
    for (genvar c = 0; c < REG_W / NIB_W; c++) begin : g_c
      if (c < CH_PER_REG) begin : g_live
        assign set_v[g*REG_W + c*NIB_W +: NIB_W] =
          {1'b0, ev_queue[g*CH_PER_REG+c], ev_pkg[g*CH_PER_REG+c], ev_half[g*CH_PER_REG+c]};
      end else begin : g_dead
        assign set_v[g*REG_W + c*NIB_W +: NIB_W] = '0;
      end
      assign clr_v[g*REG_W + c*NIB_W +: NIB_W] = hit_st ? wdata[c*NIB_W +: NIB_W] : '0;
    end
  end

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_all & rsv_all) == '0) && ((st_all & rsv_all) == '0)); // R2

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_all)); // R2

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_all & $past(set_v)) == $past(set_v))); // R5

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_all & ~$past(st_all) & ~$past(set_v)) == '0)); // R3

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_all & $past(clr_v & ~set_v)) == '0)); // R4

  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(st_all & en_all)))); // R6
endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .ev_half  (ev_half),
  .ev_pkg   (ev_pkg),
  .ev_queue (ev_queue),
  .irq      (irq),
  .en_all   (en_all),
  .st_all   (st_all)
);

// File: tb/tb_dma_irq_bank.sv
`timescale 1ns/1ps
module tb_dma_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] ev_half = '0, ev_pkg = '0, ev_queue = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_half(ev_half), .ev_pkg(ev_pkg), .ev_queue(ev_queue),
    .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [15:0] h;
    logic [15:0] p;
    logic [15:0] q;
    logic [7:0]  ra;
    logic [31:0] er;
    logic        ei;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000, 8'h00, 32'h7777_7777, 1'b0, 8'd2}, // R2 bit3 masked
    '{1'b1, 8'h04, 32'h0000_F002, 16'h0000, 16'h0000, 16'h0000, 8'h04, 32'h0000_7002, 1'b0, 8'd2}, // R2 ch8 pkg, ch11
    '{1'b0, 8'h00, 32'h0,         16'h0001, 16'h0000, 16'h0000, 8'h10, 32'h0000_0001, 1'b1, 8'd3}, // R3 half ch0
    '{1'b1, 8'h10, 32'h0000_0001, 16'h0000, 16'h0000, 16'h0000, 8'h10, 32'h0000_0000, 1'b0, 8'd4}, // R4 clear
    '{1'b0, 8'h00, 32'h0,         16'h0000, 16'h0000, 16'h0200, 8'h14, 32'h0000_0040, 1'b0, 8'd3}, // R3 latch unenabled
    '{1'b0, 8'h00, 32'h0,         16'h0000, 16'h0100, 16'h0000, 8'h14, 32'h0000_0042, 1'b1, 8'd6}, // R6 enabled pkg
    '{1'b0, 8'h00, 32'h0,         16'h0000, 16'h0000, 16'h0000, 8'h30, 32'h0000_0300, 1'b1, 8'd7}, // R7 summary
    '{1'b1, 8'h14, 32'h0000_0040, 16'h0000, 16'h0000, 16'h0000, 8'h14, 32'h0000_0002, 1'b1, 8'd4}, // R4 partial clear
    '{1'b1, 8'h14, 32'h0000_0002, 16'h0000, 16'h0100, 16'h0000, 8'h14, 32'h0000_0002, 1'b1, 8'd5}, // R5 event wins
    '{1'b1, 8'h14, 32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000, 8'h14, 32'h0000_0000, 1'b0, 8'd4}, // R4 clear all
    '{1'b0, 8'h00, 32'h0,         16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h10, 32'h7777_7777, 1'b1, 8'd3}, // R3 all events
    '{1'b1, 8'h30, 32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000, 8'h30, 32'h0000_FFFF, 1'b1, 8'd7}, // R7 read-only
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000, 8'h20, 32'h0000_0000, 1'b1, 8'd8}, // R8 unmapped
    '{1'b1, 8'h00, 32'h0000_0000, 16'h0000, 16'h0000, 16'h0000, 8'h14, 32'h7777_7777, 1'b1, 8'd9}, // R9 one half masked
    '{1'b1, 8'h04, 32'h0000_0000, 16'h0000, 16'h0000, 16'h0000, 8'h10, 32'h7777_7777, 1'b0, 8'd9}, // R9 both masked
    '{1'b1, 8'h10, 32'h7777_7777, 16'h0000, 16'h0000, 16'h0000, 8'h10, 32'h0000_0000, 1'b0, 8'd4}, // R4
    '{1'b1, 8'h00, 32'h0000_0010, 16'h0002, 16'h0000, 16'h0000, 8'h10, 32'h0000_0010, 1'b1, 8'd6}, // R6 ch1 half
    '{1'b1, 8'h00, 32'h8888_8888, 16'h0000, 16'h0000, 16'h0000, 8'h00, 32'h0000_0000, 1'b0, 8'd2}  // R2 reserved only
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    read_chk("R1", 8'h00, 32'h0);
    read_chk("R1", 8'h04, 32'h0);
    read_chk("R1", 8'h10, 32'h0);
    read_chk("R1", 8'h14, 32'h0);
    read_chk("R1", 8'h30, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      @(negedge clk);
      wr_en = v.wr; addr = v.a; wdata = v.d;
      ev_half = v.h; ev_pkg = v.p; ev_queue = v.q;
      @(negedge clk);
      wr_en = 1'b0; ev_half = '0; ev_pkg = '0; ev_queue = '0;
      read_chk($sformatf("R%0d vec%0d rdata", v.req, i), v.ra, v.er);
      @(negedge clk);
      #1;
      chk($sformatf("R%0d vec%0d irq", v.req, i), {31'b0, irq}, {31'b0, v.ei});
    end

    // R1: reset while state is live
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_chk("R1 after reset", 8'h14, 32'h0);
    read_chk("R1 after reset", 8'h10, 32'h0);
    read_chk("R1 after reset", 8'h00, 32'h0);
    chk("R1 after reset irq", {31'b0, irq}, 32'h0);

    // R6: irq latency counted edge by edge
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h04; wdata = 32'h4000_0000;  // ch15 queue enable
    @(negedge clk);
    wr_en = 1'b0; ev_queue = 16'h8000;
    @(negedge clk);
    ev_queue = '0;
    read_chk("R3 ch15 queue", 8'h14, 32'h4000_0000);
    chk("R6 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    #1;
    chk("R6 irq raised", {31'b0, irq}, 32'h1);
    wr_en = 1'b1; addr = 8'h14; wdata = 32'h4000_0000;
    @(negedge clk);
    wr_en = 1'b0;
    read_chk("R4 ch15 cleared", 8'h14, 32'h0);
    chk("R6 irq held one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    #1;
    chk("R6 irq dropped", {31'b0, irq}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule